// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block drives a successive-approximation analog-to-digital converter from two byte-wide registers. A channel register picks one of eight analog inputs. A control register enables the converter, starts conversions, and holds the completion flag, the interrupt enable and a 3-bit clock divider code. The block does not contain the analog parts. It presents a channel select and a trial DAC code, and reads back one comparator bit per step. The finished code goes into a result register, the completion flag is set, and an interrupt request is raised when enabled.

The state machine has five states: `ST_IDLE`, `ST_INIT` (the discarded initialisation pass), `ST_SAMPLE`, `ST_CONV` (one step per result bit, MSB first) and `ST_WRBACK` (two slots before the result is written). The transitions are:

- IDLE→INIT on a start when initialisation is still owed.
- IDLE→SAMPLE on any other start.
- INIT→SAMPLE after the initialisation tick count.
- SAMPLE→CONV after one tick.
- CONV→WRBACK after the LSB step.
- WRBACK→SAMPLE if a start is pending, otherwise WRBACK→IDLE.
- Any state→IDLE when the enable is cleared.

All timing advances on a divided tick taken from the system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the channel register, control register, result register and the interrupt request are all zero.
- R2: The channel register reads its written bits 2..0, and bits 7..3 always read 0. The control register has enable at bit 7, start at bit 6, a reserved bit 5 that reads 0, the completion flag at bit 4, the interrupt enable at bit 3, and the divider code at bits 2..0.
- R3: Divider code c sets the tick period to 2 clocks for c=0, and to 2^c clocks for c=1..7.
- R4: The first start after the enable rises, including a start written together with the enable, first runs an initialisation pass of 2*RES_W+5 ticks. That pass leaves the result and the flag untouched.
- R5: A real conversion takes RES_W+3 ticks: 1 tick of sampling, RES_W trial steps from MSB to LSB, and 2 write-back ticks. A trial bit is kept when cmp_in is 1 (input at or above dac_code). The result is the final code.
- R6: The start bit reads 1 from the start write until the real conversion ends, including any initialisation pass. It falls exactly 2 ticks before the result and the flag are written.
- R7: A start written while a conversion is running is held. Its conversion enters sampling on the same tick that the running one writes its result.
- R8: Clearing the enable aborts at once. The start bit reads 0, no flag is set, and the result is unchanged.
- R9: Writing 0 to the start bit has no effect on a running conversion. A start written while the enable stays 0 is ignored.
- R10: Each completed real conversion sets the flag. Writing 1 to the flag bit clears it, and writing 0 leaves it unchanged.
- R11: irq is 1 exactly when both the flag and the interrupt enable are 1.
- R12: mux_sel takes the channel register value at the start of each conversion and holds it until that conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the channel register, 1 selects the control register |
| reg_wdata | input | 8 | Write data |
| chan_rd | output | 8 | Channel register readback |
| ctrl_rd | output | 8 | Control register readback |
| result_rd | output | RES_W (10) | Last conversion result |
| mux_sel | output | 3 | Analog input select |
| dac_code | output | RES_W (10) | Trial code for the DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above dac_code |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with RES_W=6. This keeps the trial-step count short enough that every one of the 64 possible codes can be converted through a comparator model, with the channel rotating across all eight inputs. All eight divider codes are also run. Each run checks its latency window and the exact two-tick gap between the start bit falling and the flag rising. The smaller width also makes the initialisation pass, the held start and the abort cheap enough to run at several points in the sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_SAMPLE,
        ST_CONV,
        ST_WRBACK
    } seq_state_t;

    localparam int CTRL_EN    = 7;
    localparam int CTRL_START = 6;
    localparam int CTRL_FLAG  = 4;
    localparam int CTRL_IE    = 3;
    localparam int PSC_W      = 3;
    localparam int CHAN_W     = 3;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // Code 0 and code 1 both divide by two; code c otherwise divides by 2^c.
    always_comb begin
        mask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i == 0 || i < int'(psc)) mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!run) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign tick = run && ((cnt & mask) == mask);
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] code,
    output logic         last
);
    localparam int POS_W = (W > 1) ? $clog2(W) : 1;

    logic [POS_W-1:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            pos  <= '0;
        end else if (load) begin
            code        <= '0;
            code[W-1]   <= 1'b1;
            pos         <= POS_W'(W-1);
        end else if (step) begin
            if (!cmp) code[pos] <= 1'b0;
            if (pos != '0) begin
                code[pos - 1'b1] <= 1'b1;
                pos              <= pos - 1'b1;
            end
        end
    end

    assign last = (pos == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       chan_rd,
    output logic [7:0]       ctrl_rd,
    output logic [RES_W-1:0] result_rd,
    output logic [2:0]       mux_sel,
    output logic [RES_W-1:0] dac_code,
    input  logic             cmp_in,
    output logic             irq
);
    localparam int INIT_TICKS = 2 * RES_W + 5;
    localparam int STEP_W     = $clog2(INIT_TICKS);

    seq_state_t state, st_n;

    logic              en_q, ie_q, flag_q, queued_q, need_init_q;
    logic [PSC_W-1:0]  psc_q;
    logic [CHAN_W-1:0] chan_q, chan_lat_q;
    logic [RES_W-1:0]  result_q;
    logic [STEP_W-1:0] step_cnt;

    logic wr_ctrl, wr_chan, en_next, en_rise, start_req;
    logic tick, sar_load, sar_step, sar_last, wb_done, busy;
    logic [RES_W-1:0] sar_code;

    assign wr_ctrl   = reg_wr && reg_addr;
    assign wr_chan   = reg_wr && !reg_addr;
    assign en_next   = wr_ctrl ? reg_wdata[CTRL_EN] : en_q;
    assign en_rise   = wr_ctrl && reg_wdata[CTRL_EN] && !en_q;
    assign start_req = wr_ctrl && reg_wdata[CTRL_EN] && reg_wdata[CTRL_START];

    adc_tick_gen #(.PSC_W(PSC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q),
        .psc   (psc_q),
        .tick  (tick)
    );

    adc_sar_reg #(.W(RES_W)) u_sar (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sar_load),
        .step  (sar_step),
        .cmp   (cmp_in),
        .code  (sar_code),
        .last  (sar_last)
    );

    // Next-state logic
    always_comb begin
        st_n     = state;
        sar_load = 1'b0;
        sar_step = 1'b0;
        wb_done  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_req) st_n = (need_init_q || en_rise) ? ST_INIT : ST_SAMPLE;
            end
            ST_INIT: begin
                if (tick && step_cnt == STEP_W'(INIT_TICKS - 1)) st_n = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (tick) begin
                    sar_load = 1'b1;
                    st_n     = ST_CONV;
                end
            end
            ST_CONV: begin
                if (tick) begin
                    sar_step = 1'b1;
                    if (sar_last) st_n = ST_WRBACK;
                end
            end
            ST_WRBACK: begin
                if (tick && step_cnt == STEP_W'(1)) begin
                    wb_done = 1'b1;
                    st_n    = (queued_q || start_req) ? ST_SAMPLE : ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (!en_next) begin
            st_n     = ST_IDLE;
            sar_load = 1'b0;
            sar_step = 1'b0;
            wb_done  = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_n;
    end

    // Register file and sequencing state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            ie_q        <= 1'b0;
            psc_q       <= '0;
            flag_q      <= 1'b0;
            chan_q      <= '0;
            chan_lat_q  <= '0;
            result_q    <= '0;
            queued_q    <= 1'b0;
            need_init_q <= 1'b0;
            step_cnt    <= '0;
        end else begin
            if (wr_chan) chan_q <= reg_wdata[CHAN_W-1:0];
            if (wr_ctrl) begin
                en_q  <= reg_wdata[CTRL_EN];
                ie_q  <= reg_wdata[CTRL_IE];
                psc_q <= reg_wdata[PSC_W-1:0];
            end

            if (wb_done)                              flag_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[CTRL_FLAG]) flag_q <= 1'b0;

            if (wb_done) result_q <= sar_code;

            if (st_n == ST_SAMPLE && state != ST_SAMPLE) chan_lat_q <= chan_q;

            queued_q <= en_next && !(wb_done && st_n == ST_SAMPLE)
                        && (queued_q || (start_req && state != ST_IDLE));

            if (st_n == ST_INIT) need_init_q <= 1'b0;
            else if (en_rise)    need_init_q <= 1'b1;

            if (st_n != state) step_cnt <= '0;
            else if (tick)     step_cnt <= step_cnt + 1'b1;
        end
    end

    // Output logic
    always_comb begin
        busy      = (state == ST_INIT) || (state == ST_SAMPLE) || (state == ST_CONV);
        chan_rd   = {{(8-CHAN_W){1'b0}}, chan_q};
        ctrl_rd   = {en_q, busy || queued_q, 1'b0, flag_q, ie_q, psc_q};
        result_rd = result_q;
        mux_sel   = chan_lat_q;
        dac_code  = sar_code;
        irq       = flag_q && ie_q;
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       chan_rd,
    input logic [7:0]       ctrl_rd,
    input logic [RES_W-1:0] result_rd,
    input logic [2:0]       mux_sel,
    input logic             irq,
    input seq_state_t       state
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rd[7:3] == 5'd0 && ctrl_rd[5] == 1'b0);

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rd[CTRL_EN] |-> !ctrl_rd[CTRL_START] && state == ST_IDLE);

    // R5
    result_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_rd) |-> ctrl_rd[CTRL_FLAG]);

    // R12
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && $past(state) == ST_CONV) |-> $stable(mux_sel));

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_rd[CTRL_IE] && ctrl_rd[CTRL_FLAG]);

    // R6
    start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rd[CTRL_START]) && ctrl_rd[CTRL_EN] |-> state == ST_WRBACK);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_rd   (chan_rd),
    .ctrl_rd   (ctrl_rd),
    .result_rd (result_rd),
    .mux_sel   (mux_sel),
    .irq       (irq),
    .state     (state)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int RW = 6;
    localparam int T_REAL = RW + 3;
    localparam int T_INIT = 2 * RW + 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    chan_rd, ctrl_rd;
    logic [RW-1:0] result_rd, dac_code;
    logic [2:0]    mux_sel;
    logic          cmp_in, irq;
    logic [RW-1:0] analog [8];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit tb_ie = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_seq_ctrl #(.RES_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .chan_rd(chan_rd), .ctrl_rd(ctrl_rd),
        .result_rd(result_rd), .mux_sel(mux_sel), .dac_code(dac_code),
        .cmp_in(cmp_in), .irq(irq)
    );

    assign cmp_in = analog[mux_sel] >= dac_code;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] ctl(bit en, bit st, bit fl, bit ie, int psc);
        return {en, st, 1'b0, fl, ie, 3'(psc)};
    endfunction

    function automatic int divof(int psc);
        return (psc == 0) ? 2 : (1 << psc);
    endfunction

    // Waits at negedges until the flag reads 1; reports the cycle of the flag and of the start-bit fall.
    task automatic wait_flag(output int fcyc, output int fallcyc, output bit ok);
        bit prev;
        int n;
        prev = ctrl_rd[6];
        fallcyc = -1;
        n = 0;
        while (!ctrl_rd[4] && n < 20000) begin
            @(negedge clk);
            n++;
            if (prev && !ctrl_rd[6]) fallcyc = cyc;
            prev = ctrl_rd[6];
        end
        fcyc = cyc;
        ok = ctrl_rd[4];
    endtask

    task automatic do_conv(input int psc, input int ch, input int val, input bit init, input string req);
        int c0, fc, fl, lo, hi, d, n;
        bit ok;
        analog[ch] = RW'(val);
        wr(1'b0, 8'(ch));
        wr(1'b1, ctl(1, 1, 1, tb_ie, psc));
        c0 = cyc;
        wait_flag(fc, fl, ok);
        d = divof(psc);
        n = fc - c0;
        lo = ((init ? T_INIT : 0) + T_REAL - 1) * d + 1;
        hi = ((init ? T_INIT : 0) + T_REAL) * d;
        chk(ok, {req, " flag set"}, ok, 1);
        chk(result_rd == RW'(val), {req, " result"}, result_rd, val);
        chk(n >= lo && n <= hi, {req, " latency"}, n, init ? hi : lo);
        chk(fc - fl == 2 * d, "R6 start-fall to flag", fc - fl, 2 * d);
    endtask

    initial begin
        int fc, fl, c0;
        bit ok;
        logic [RW-1:0] keep;
        for (int i = 0; i < 8; i++) analog[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk(chan_rd == 8'h00, "R1 chan", chan_rd, 0);
        chk(ctrl_rd == 8'h00, "R1 ctrl", ctrl_rd, 0);
        chk(result_rd == '0, "R1 result", result_rd, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R2 reserved bits
        wr(1'b0, 8'hFF);
        chk(chan_rd == 8'h07, "R2 chan reserved", chan_rd, 7);
        wr(1'b1, 8'h20);
        chk(ctrl_rd == 8'h00, "R2 ctrl reserved", ctrl_rd, 0);

        // R9 start ignored while enable stays 0
        wr(1'b1, 8'h40);
        repeat (200) @(negedge clk);
        chk(ctrl_rd == 8'h00, "R9 start while disabled", ctrl_rd, 0);

        // R4 enable and start together: initialisation pass first
        do_conv(0, 3, 45, 1'b1, "R4 same-write init");
        // R5 next start runs without initialisation
        do_conv(0, 4, 19, 1'b0, "R5 real conversion");

        // R5 R12 every code, channel rotating
        for (int v = 0; v < (1 << RW); v++) do_conv(0, v % 8, v, 1'b0, "R5 R12 sweep");

        // R3 every divider code
        for (int p = 0; p < 8; p++) do_conv(p, p, 37 + p, 1'b0, "R3 divider");

        // R4 enable alone, start later
        wr(1'b1, 8'h10);
        wr(1'b1, ctl(1, 0, 0, 0, 1));
        repeat (50) @(negedge clk);
        do_conv(1, 6, 27, 1'b1, "R4 first start after enable");

        // R9 writing 0 to start mid-conversion
        analog[2] = RW'(58);
        wr(1'b0, 8'd2);
        wr(1'b1, ctl(1, 1, 1, 0, 2));
        repeat (10) @(negedge clk);
        wr(1'b1, ctl(1, 0, 0, 0, 2));
        chk(ctrl_rd[6] == 1'b1, "R9 start-0 keeps start bit", ctrl_rd[6], 1);
        wait_flag(fc, fl, ok);
        chk(ok && result_rd == RW'(58), "R9 start-0 no effect on result", result_rd, 58);

        // R10 write 0 leaves flag, write 1 clears it
        wr(1'b1, ctl(1, 0, 0, 0, 2));
        chk(ctrl_rd[4] == 1'b1, "R10 write 0 keeps flag", ctrl_rd[4], 1);
        wr(1'b1, ctl(1, 0, 1, 0, 2));
        chk(ctrl_rd[4] == 1'b0, "R10 write 1 clears flag", ctrl_rd[4], 0);

        // R7 R12 held start and channel change mid-conversion
        analog[1] = RW'(11);
        analog[5] = RW'(50);
        wr(1'b0, 8'd1);
        wr(1'b1, ctl(1, 1, 0, 0, 1));
        repeat (6) @(negedge clk);
        wr(1'b0, 8'd5);
        wr(1'b1, ctl(1, 1, 0, 0, 1));
        wait_flag(fc, fl, ok);
        chk(result_rd == RW'(11), "R12 first uses old channel", result_rd, 11);
        chk(ctrl_rd[6] == 1'b1, "R7 start held at first flag", ctrl_rd[6], 1);
        c0 = fc;
        wr(1'b1, ctl(1, 0, 1, 0, 1));
        wait_flag(fc, fl, ok);
        chk(result_rd == RW'(50), "R7 R12 second uses new channel", result_rd, 50);
        chk(fc - c0 == T_REAL * 2, "R7 back-to-back spacing", fc - c0, T_REAL * 2);

        // R11 irq gating
        tb_ie = 1'b1;
        do_conv(0, 0, 9, 1'b0, "R11 conv");
        chk(irq == 1'b1, "R11 irq with ie", irq, 1);
        wr(1'b1, ctl(1, 0, 1, 1, 0));
        chk(irq == 1'b0, "R11 irq after clear", irq, 0);
        tb_ie = 1'b0;
        do_conv(0, 0, 9, 1'b0, "R11 conv");
        chk(irq == 1'b0, "R11 irq without ie", irq, 0);

        // R8 abort on disable
        keep = result_rd;
        analog[7] = RW'(33);
        wr(1'b0, 8'd7);
        wr(1'b1, ctl(1, 1, 1, 0, 3));
        repeat (30) @(negedge clk);
        wr(1'b1, 8'h00);
        chk(ctrl_rd[6] == 1'b0, "R8 start bit low after abort", ctrl_rd[6], 0);
        repeat (400) @(negedge clk);
        chk(ctrl_rd[4] == 1'b0, "R8 no flag after abort", ctrl_rd[4], 0);
        chk(result_rd == keep, "R8 result unchanged", result_rd, keep);
        do_conv(0, 7, 33, 1'b1, "R4 R8 re-enable runs init");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule